// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands of parameterised width using one full-adder cell, spread over one bit per clock. Each operand is written into its own register through a shared parallel operand bus, using a separate load strobe for each register. A start pulse then begins the addition. While it runs, both operand registers shift right by one place per cycle. The full adder combines their low bits with a registered carry. Each sum bit enters the result register at its top end, so after the last shift the least significant result bit sits at bit 0.

When the last shift is done, the busy flag drops and a one-cycle done pulse marks the result as ready. The full result is then read in parallel, together with the final carry, which signals that the true sum does not fit in the operand width. The design needs very little logic: one adder cell, three registers, one carry flip-flop and a small counter. The cost is latency: one addition takes as many cycles as the operand has bits.

Top module: `bss_adder`

## Requirements
- R1: While reset is high and after it is released, busy, done, the parallel result and the carry output are all 0 until the first operation.
- R2: After an operation, the result equals (A + B) mod 2^WIDTH, where A and B are the values on the operand bus at the last accepted X and Y loads.
- R3: After an operation, the carry output equals bit WIDTH of A + B, so it is 1 exactly when the sum overflows WIDTH bits.
- R4: A start accepted while idle makes busy high for exactly WIDTH consecutive cycles, starting in the cycle after the accepting edge.
- R5: Done is high for exactly one cycle. That cycle directly follows the last busy cycle, and busy is low while done is high.
- R6: An accepted start clears the carry flip-flop, so a carry left from an earlier operation never enters a new sum.
- R7: While busy, the X load strobe, the Y load strobe and start are ignored, and the running result is not disturbed.
- R8: While idle, the result and carry outputs hold their values, including when operand loads occur.
- R9: A load or start that arrives on the same edge as an accepted start still takes effect: loads made before start are the operands used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| opnd_i | input | WIDTH | Parallel operand bus |
| ld_x_i | input | 1 | Load the operand bus into the X register (idle only) |
| ld_y_i | input | 1 | Load the operand bus into the Y register (idle only) |
| start_i | input | 1 | Begin an addition (idle only) |
| busy_o | output | 1 | High during the WIDTH shift cycles |
| done_o | output | 1 | One-cycle pulse after the last shift |
| sum_o | output | WIDTH | Parallel result register |
| carry_o | output | 1 | Final carry, unsigned overflow flag |

## Verification
The bench builds the adder with WIDTH set to 4. At that width, every one of the 256 operand pairs can be run and checked for both result and carry against a behavioural sum. The exhaustive sweep reaches every carry pattern the cell can produce, including an overflowing operation followed directly by one that does not overflow, which exposes any stale carry. At this width the busy window is short enough to count cycle by cycle, and loads and starts can be injected in the middle of an operation.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // width of a counter able to hold values 0 .. n-1
  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bss_full_adder.sv
module bss_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic prop;

  assign prop = a_i ^ b_i;
  assign s_o  = prop ^ c_i;
  assign c_o  = (c_i & prop) | (a_i & b_i);

endmodule

// File: rtl/bss_shift_reg.sv
module bss_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_en_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_en_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_r;

  // right shift: serial bit enters at the top, bit 0 leaves first
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_r <= '0;
    end else if (load_en_i) begin
      q_r <= load_val_i;
    end else if (shift_en_i) begin
      if (WIDTH > 1) q_r <= {ser_i, q_r[WIDTH-1:1]};
      else           q_r <= {WIDTH{ser_i}};
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/bss_sequencer.sv
module bss_sequencer #(
  parameter int WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic accept_o,
  output logic shift_en_o,
  output logic busy_o,
  output logic done_o
);

  import bss_pkg::*;

  localparam int CW = cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  seq_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            done_q;
  logic            accept;

  assign accept = start_i && (state_q == SEQ_IDLE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
          end
        end
        SEQ_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign accept_o   = accept;
  assign shift_en_o = (state_q == SEQ_RUN);
  assign busy_o     = (state_q == SEQ_RUN);
  assign done_o     = done_q;

endmodule

// File: rtl/bss_adder.sv
module bss_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             ld_x_i,
  input  logic             ld_y_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  logic             accept;
  logic             shift_en;
  logic             busy;
  logic [WIDTH-1:0] x_q;
  logic [WIDTH-1:0] y_q;
  logic [WIDTH-1:0] sum_q;
  logic             carry_q;
  logic             fa_s;
  logic             fa_co;

  bss_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .accept_o   (accept),
    .shift_en_o (shift_en),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  // operand registers: parallel load while idle, zero fill on shift
  bss_shift_reg #(.WIDTH(WIDTH)) u_xreg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_en_i  (ld_x_i & ~busy),
    .load_val_i (opnd_i),
    .shift_en_i (shift_en),
    .ser_i      (1'b0),
    .q_o        (x_q)
  );

  bss_shift_reg #(.WIDTH(WIDTH)) u_yreg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_en_i  (ld_y_i & ~busy),
    .load_val_i (opnd_i),
    .shift_en_i (shift_en),
    .ser_i      (1'b0),
    .q_o        (y_q)
  );

  bss_full_adder u_fa (
    .a_i (x_q[0]),
    .b_i (y_q[0]),
    .c_i (carry_q),
    .s_o (fa_s),
    .c_o (fa_co)
  );

  // result register: new sum bit enters at the MSB
  bss_shift_reg #(.WIDTH(WIDTH)) u_sreg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_en_i  (1'b0),
    .load_val_i ('0),
    .shift_en_i (shift_en),
    .ser_i      (fa_s),
    .q_o        (sum_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)         carry_q <= 1'b0;
    else if (accept)   carry_q <= 1'b0;
    else if (shift_en) carry_q <= fa_co;
  end

  assign busy_o  = busy;
  assign sum_o   = sum_q;
  assign carry_o = carry_q;

endmodule

// File: rtl/bss_adder_chk.sv
module bss_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o
);

  int run_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i)       run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  // R4: busy window length
  a_r4_busy_len: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> (run_cnt == WIDTH));

  // R4: accepted start raises busy
  a_r4_start_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o) |=> busy_o);

  // R5: done follows last busy cycle
  a_r5_done_after_run: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> done_o);

  // R5: done and busy exclusive
  a_r5_done_not_busy: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !busy_o);

  // R5: single cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R6: accepted start clears carry
  a_r6_carry_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o) |=> !carry_o);

  // R8: result holds while idle
  a_r8_sum_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |=> $stable(sum_o));

  // R8: carry holds while idle without start
  a_r8_carry_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && !start_i) |=> $stable(carry_o));

endmodule

bind bss_adder bss_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sum_o   (sum_o),
  .carry_o (carry_o)
);

// File: tb/bss_adder_bench.sv
module bss_adder_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd = '0;
  logic         ld_x = 1'b0;
  logic         ld_y = 1'b0;
  logic         start = 1'b0;
  logic         busy;
  logic         done;
  logic [W-1:0] sum;
  logic         carry;

  int checks = 0;
  int failures = 0;
  int busy_cnt = 0;
  logic prev_done = 1'b0;
  logic [W:0] exp_q[$];
  logic [W:0] last_res = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  bss_adder #(.WIDTH(W)) u_bss_adder (
    .clk_i   (clk),
    .rst_i   (rst),
    .opnd_i  (opnd),
    .ld_x_i  (ld_x),
    .ld_y_i  (ld_y),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done),
    .sum_o   (sum),
    .carry_o (carry)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) busy_cnt++;
      if (done && prev_done) check("R5 done width", 32'd2, 32'd1);
      if (done) begin
        check("R5 busy low with done", {31'd0, busy}, 32'd0);
        check("R4 busy length", busy_cnt, W);
        busy_cnt = 0;
        if (exp_q.size() == 0) begin
          check("R2 unexpected done", 32'd1, 32'd0);
        end else begin
          logic [W:0] e;
          e = exp_q.pop_front();
          check("R2 sum", {{(32-W){1'b0}}, sum}, {{(32-W){1'b0}}, e[W-1:0]});
          check("R3 carry", {31'd0, carry}, {31'd0, e[W]});
          last_res = e;
        end
      end
      prev_done = done;
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    @(negedge clk); opnd = a; ld_x = 1'b1;
    @(negedge clk); ld_x = 1'b0; opnd = b; ld_y = 1'b1;
    @(negedge clk); ld_y = 1'b0; start = 1'b1;
    exp_q.push_back({1'b0, a} + {1'b0, b});
    @(negedge clk); start = 1'b0;
    if (disturb) begin
      // R7: loads and start while busy must be ignored
      @(negedge clk); opnd = ~a; ld_x = 1'b1; ld_y = 1'b1; start = 1'b1;
      @(negedge clk); ld_x = 1'b0; ld_y = 1'b0; start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 sum", {{(32-W){1'b0}}, sum}, 32'd0);
    check("R1 carry", {31'd0, carry}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {30'd0, busy, done}, 32'd0);

    // R6: overflow then non-overflow back to back
    run_op(4'hF, 4'h1, 1'b0);
    run_op(4'h1, 4'h1, 1'b0);

    // R2 R3: exhaustive sweep
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_op(W'(a), W'(b), 1'b0);

    // R7: disturbed operations
    run_op(4'h9, 4'h8, 1'b1);
    run_op(4'h3, 4'h6, 1'b1);

    // R8: result holds while idle, even across loads
    @(negedge clk);
    opnd = 4'hA; ld_x = 1'b1; ld_y = 1'b1;
    @(negedge clk); ld_x = 1'b0; ld_y = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 sum hold", {{(32-W){1'b0}}, sum}, {{(32-W){1'b0}}, last_res[W-1:0]});
    check("R8 carry hold", {31'd0, carry}, {31'd0, last_res[W]});
    check("R7 no stray done", {31'd0, done}, 32'd0);

    // R9: load X and start on same edge, Y loaded earlier
    @(negedge clk); opnd = 4'h7; ld_y = 1'b1;
    @(negedge clk); ld_y = 1'b0; opnd = 4'hC; ld_x = 1'b1; start = 1'b1;
    exp_q.push_back(5'h13);
    @(negedge clk); ld_x = 1'b0; start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R9 queue drained", exp_q.size(), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule